// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM command bus and brings the memory from power-on to a usable state. It waits until a power-good input reports that supply and clock are stable. While it waits, it holds clock enable low with a NOP on the bus. It then raises clock enable and drives a fixed script of commands: precharge-all, four mode-register loads (the EMR2, EMR3, EMR with the DLL enabled, and the MR with a DLL reset), a second precharge-all, a run of refreshes, the operating MR, and two EMR writes that enter and then leave the default OCD state.

Every wait is derived from the clock period parameter, and NOPs fill the gaps between commands. The done output rises only after two things have happened: the last write's spacing has elapsed, and the DLL-lock window has expired. That window is counted from the DLL-reset command. After done, the block keeps the bus at NOP with clock enable high. Normal traffic then takes over the bus.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, CKE is 0, the command is NOP, BA and address are 0, and done is 0. The command nibble {CS#,RAS#,CAS#,WE#} encodes NOP=0111, PRECHARGE=0010, REFRESH=0001 and LOAD MODE=0000.
- R2: CKE stays 0 and only NOPs are driven until pwr_ok has been high for PWR_CK consecutive cycles. PWR_CK is the power-up wait in cycles, rounded up. If pwr_ok drops during this wait, the count restarts. CKE rises exactly PWR_CK clocks after pwr_ok is first sampled high.
- R3: Once CKE is high, it stays high until the next reset.
- R4: The first command is PRECHARGE with A10=1, BA=0 and all other address bits 0. It appears exactly CKE_CK clocks after CKE rises, where CKE_CK is 400 ns rounded up to clocks.
- R5: Four LOAD MODE commands follow, in this order. First, BA=2 (EMR2) with A7 equal to srf_sel and all other bits 0. Second, BA=3 (EMR3) with all bits 0. Third, BA=1 (EMR) with all bits 0, which enables the DLL with OCD bits 9:7 cleared. Fourth, BA=0 (MR) with only A8=1, which resets the DLL.
- R6: Next come a PRECHARGE with A10=1, then NUM_REF (default 2) REFRESH commands with BA=0 and address 0.
- R7: Next is a LOAD MODE with BA=0 that carries mr_cfg with bit 8 forced to 0.
- R8: Two LOAD MODE commands with BA=1 follow. Both carry emr_cfg with bit 0 forced to 0. The first has bits 9:7 set to 111 and the second has them cleared to 000.
- R9: Command spacing is fixed. A PRECHARGE is followed by the next command exactly RP_CK clocks later, a REFRESH by RFC_CK clocks, and a LOAD MODE by MRD_CK clocks (default 2). All cycles in between carry NOP.
- R10: Done rises in the later of two cycles: exactly DLL_LOCK_CK (default 200) clocks after the DLL-reset command, or MRD_CK clocks after the last EMR write. Once high, done stays high, and only NOPs follow.
- R11: CS# is held at 0 on every cycle; the block never deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | High when supplies and clock are stable |
| mr_cfg | input | 14 | Operating mode-register value (bit 8 ignored) |
| emr_cfg | input | 14 | Operating extended-mode value (bits 9:7 and 0 ignored) |
| srf_sel | input | 1 | Self-refresh rate select written to EMR2 bit 7 |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address / mode-register select |
| ddr_addr | output | 14 | Address bus / mode-register value |
| init_done | output | 1 | Device ready for normal operation |

## Verification
The full script runs twice with contrasting configurations. The first run sets srf_sel, bit 8 of mr_cfg, and bits 0 and 9 of emr_cfg. The second run clears srf_sel and bit 8 of mr_cfg and uses a different emr_cfg. Together the two runs separate a field that is forced from one that is passed through, and show whether the self-refresh bit reaches EMR2. Each observed command is compared against a table of opcode, bank select, address kind and spacing from the previous command, which exposes reordering and timing slips. A pwr_ok pulse that ends before the power-up wait completes checks that the wait restarts and does not resume. A timestamp on done, taken against the DLL-reset command, catches early release.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    localparam int ADDR_W = 14;
    localparam int BA_W   = 2;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    typedef struct packed {
        ddr_cmd_e          cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } bus_word_t;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_PRE1,
        ST_EMR2,
        ST_EMR3,
        ST_EMR_DLL,
        ST_MR_RST,
        ST_PRE2,
        ST_REF,
        ST_MR_OP,
        ST_OCD_IN,
        ST_OCD_OUT,
        ST_LOCK,
        ST_DONE
    } step_e;

    localparam logic [BA_W-1:0] SEL_MR   = 2'b00;
    localparam logic [BA_W-1:0] SEL_EMR  = 2'b01;
    localparam logic [BA_W-1:0] SEL_EMR2 = 2'b10;
    localparam logic [BA_W-1:0] SEL_EMR3 = 2'b11;

    localparam int BIT_PRE_ALL = 10;
    localparam int BIT_DLL_RST = 8;
    localparam int BIT_SRF     = 7;
    localparam int BIT_DLL_DIS = 0;
    localparam logic [ADDR_W-1:0] OCD_MASK = 14'h0380;

    localparam bus_word_t NOP_WORD = '{cmd: CMD_NOP, ba: '0, addr: '0};

    function automatic int ceil_cycles(input longint dur_ps, input longint tck_ps);
        longint n;
        n = (dur_ps + tck_ps - 1) / tck_ps;
        if (n < 1) n = 1;
        return int'(n);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RST_VAL;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign idle = (cnt_q == '0);
endmodule

// File: rtl/ddr2_dll_lock_cnt.sv
module ddr2_dll_lock_cnt #(
    parameter int LOCK_CK = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CK + 1);

    logic [CW-1:0] remain_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            armed_q  <= 1'b0;
        end else if (start) begin
            remain_q <= CW'(LOCK_CK - 1);
            armed_q  <= 1'b1;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign locked = armed_q && (remain_q == '0);
endmodule

// File: rtl/ddr2_init_step_rom.sv
module ddr2_init_step_rom
    import ddr2_init_pkg::*;
#(
    parameter int TW     = 8,
    parameter int RP_CK  = 1,
    parameter int MRD_CK = 2,
    parameter int RFC_CK = 8
) (
    input  step_e             step,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic              srf_sel,
    output bus_word_t         word,
    output logic [TW-1:0]     gap
);
    logic [ADDR_W-1:0] emr_user;

    always_comb begin
        emr_user              = emr_cfg & ~OCD_MASK;
        emr_user[BIT_DLL_DIS] = 1'b0;
        word = NOP_WORD;
        gap  = TW'(MRD_CK);
        case (step)
            ST_PRE1, ST_PRE2: begin
                word.cmd               = CMD_PRE;
                word.addr[BIT_PRE_ALL] = 1'b1;
                gap                    = TW'(RP_CK);
            end
            ST_EMR2: begin
                word.cmd           = CMD_LMR;
                word.ba            = SEL_EMR2;
                word.addr[BIT_SRF] = srf_sel;
            end
            ST_EMR3: begin
                word.cmd = CMD_LMR;
                word.ba  = SEL_EMR3;
            end
            ST_EMR_DLL: begin
                word.cmd = CMD_LMR;
                word.ba  = SEL_EMR;
            end
            ST_MR_RST: begin
                word.cmd               = CMD_LMR;
                word.ba                = SEL_MR;
                word.addr[BIT_DLL_RST] = 1'b1;
            end
            ST_REF: begin
                word.cmd = CMD_REF;
                gap      = TW'(RFC_CK);
            end
            ST_MR_OP: begin
                word.cmd               = CMD_LMR;
                word.ba                = SEL_MR;
                word.addr              = mr_cfg;
                word.addr[BIT_DLL_RST] = 1'b0;
            end
            ST_OCD_IN: begin
                word.cmd  = CMD_LMR;
                word.ba   = SEL_EMR;
                word.addr = emr_user | OCD_MASK;
            end
            ST_OCD_OUT: begin
                word.cmd  = CMD_LMR;
                word.ba   = SEL_EMR;
                word.addr = emr_user;
            end
            default: begin
                word = NOP_WORD;
            end
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int T_CK_PS     = 5000,
    parameter int PWRUP_NS    = 200000,
    parameter int CKE_PRE_NS  = 400,
    parameter int T_RP_PS     = 15000,
    parameter int T_RFC_PS    = 127500,
    parameter int MRD_CK      = 2,
    parameter int DLL_LOCK_CK = 200,
    parameter int NUM_REF     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic              srf_sel,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);
    localparam int PWR_CK  = ceil_cycles(longint'(PWRUP_NS) * 1000, T_CK_PS);
    localparam int CKE_CK  = ceil_cycles(longint'(CKE_PRE_NS) * 1000, T_CK_PS);
    localparam int RP_CK   = ceil_cycles(T_RP_PS, T_CK_PS);
    localparam int RFC_CK  = ceil_cycles(T_RFC_PS, T_CK_PS);
    localparam int MRD_EFF = max2(MRD_CK, 1);
    localparam int MAX_CK  = max2(max2(PWR_CK, CKE_CK), max2(max2(RP_CK, RFC_CK), MRD_EFF));
    localparam int TW      = $clog2(MAX_CK + 1);
    localparam int REF_N   = max2(NUM_REF, 2);
    localparam int RW      = $clog2(REF_N);
    localparam logic [TW-1:0] PWR_LD = TW'(PWR_CK - 1);
    localparam logic [TW-1:0] CKE_LD = TW'(CKE_CK - 1);

    step_e            step_q;
    bus_word_t        bus_q;
    logic             cke_q;
    logic             done_q;
    logic [RW-1:0]    ref_left_q;

    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_idle;
    bus_word_t        rom_word;
    logic [TW-1:0]    rom_gap;
    logic             dll_start;
    logic             dll_locked;
    logic             issue_step;

    ddr2_init_step_rom #(
        .TW     (TW),
        .RP_CK  (RP_CK),
        .MRD_CK (MRD_EFF),
        .RFC_CK (RFC_CK)
    ) u_rom (
        .step    (step_q),
        .mr_cfg  (mr_cfg),
        .emr_cfg (emr_cfg),
        .srf_sel (srf_sel),
        .word    (rom_word),
        .gap     (rom_gap)
    );

    ddr2_init_timer #(
        .W       (TW),
        .RST_VAL (PWR_LD)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .idle     (tmr_idle)
    );

    ddr2_dll_lock_cnt #(
        .LOCK_CK (DLL_LOCK_CK)
    ) u_dll (
        .clk    (clk),
        .rst    (rst),
        .start  (dll_start),
        .locked (dll_locked)
    );

    always_comb begin
        issue_step = (step_q != ST_PWR) && (step_q != ST_LOCK) && (step_q != ST_DONE);
        tmr_load   = 1'b0;
        tmr_val    = rom_gap - 1'b1;
        if (step_q == ST_PWR) begin
            if (!pwr_ok) begin
                tmr_load = 1'b1;
                tmr_val  = PWR_LD;
            end else if (tmr_idle) begin
                tmr_load = 1'b1;
                tmr_val  = CKE_LD;
            end
        end else if (issue_step && tmr_idle) begin
            tmr_load = 1'b1;
        end
        dll_start = (step_q == ST_MR_RST) && tmr_idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q     <= ST_PWR;
            bus_q      <= NOP_WORD;
            cke_q      <= 1'b0;
            done_q     <= 1'b0;
            ref_left_q <= RW'(REF_N - 1);
        end else begin
            bus_q <= NOP_WORD;
            case (step_q)
                ST_PWR: begin
                    if (pwr_ok && tmr_idle) begin
                        cke_q  <= 1'b1;
                        step_q <= ST_PRE1;
                    end
                end
                ST_REF: begin
                    if (tmr_idle) begin
                        bus_q <= rom_word;
                        if (ref_left_q != '0)
                            ref_left_q <= ref_left_q - 1'b1;
                        else
                            step_q <= ST_MR_OP;
                    end
                end
                ST_LOCK: begin
                    if (tmr_idle && dll_locked) begin
                        done_q <= 1'b1;
                        step_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    step_q <= ST_DONE;
                end
                default: begin
                    if (tmr_idle) begin
                        bus_q  <= rom_word;
                        step_q <= step_e'(step_q + 4'd1);
                    end
                end
            endcase
        end
    end

    assign ddr_cke   = cke_q;
    assign ddr_cs_n  = bus_q.cmd[3];
    assign ddr_ras_n = bus_q.cmd[2];
    assign ddr_cas_n = bus_q.cmd[1];
    assign ddr_we_n  = bus_q.cmd[0];
    assign ddr_ba    = bus_q.ba;
    assign ddr_addr  = bus_q.addr;
    assign init_done = done_q;
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int DLL_LOCK_CK = 200,
    parameter int MRD_CK      = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        ddr_cke,
    input logic        ddr_cs_n,
    input logic        ddr_ras_n,
    input logic        ddr_cas_n,
    input logic        ddr_we_n,
    input logic [1:0]  ddr_ba,
    input logic [13:0] ddr_addr,
    input logic        init_done
);
    localparam int CW = $clog2(DLL_LOCK_CK + 1);

    logic [3:0]    cmd;
    logic          is_nop;
    logic          is_lmr;
    logic          dll_seen_q;
    logic [CW-1:0] since_q;

    assign cmd    = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
    assign is_nop = (cmd == 4'b0111);
    assign is_lmr = (cmd == 4'b0000);

    always_ff @(posedge clk) begin
        if (rst) begin
            dll_seen_q <= 1'b0;
            since_q    <= '0;
        end else if (is_lmr && ddr_ba == 2'b00 && ddr_addr[8]) begin
            dll_seen_q <= 1'b1;
            since_q    <= CW'(1);
        end else if (dll_seen_q && since_q != CW'(DLL_LOCK_CK)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r3_cke_stays_high: assert property (@(posedge clk) disable iff (rst)
        ddr_cke |=> ddr_cke);

    a_r2_nop_while_cke_low: assert property (@(posedge clk) disable iff (rst)
        !ddr_cke |-> is_nop);

    a_r4_precharge_all_a10: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> ddr_addr[10]);

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop);

    a_r10_done_after_lock: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (dll_seen_q && since_q == CW'(DLL_LOCK_CK)));

    a_r11_always_selected: assert property (@(posedge clk) disable iff (rst)
        !ddr_cs_n);

    generate
        if (MRD_CK > 1) begin : g_mrd
            a_r9_lmr_then_nop: assert property (@(posedge clk) disable iff (rst)
                is_lmr |=> ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111));
        end
    endgenerate
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .DLL_LOCK_CK (DLL_LOCK_CK),
    .MRD_CK      (MRD_CK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ddr_cke   (ddr_cke),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n),
    .ddr_we_n  (ddr_we_n),
    .ddr_ba    (ddr_ba),
    .ddr_addr  (ddr_addr),
    .init_done (init_done)
);

// File: tb/ddr2_init_seq_bench.sv
`timescale 1ns/1ps
module ddr2_init_seq_bench;

    localparam int TCK_PS  = 20000;
    localparam int PWR     = (200000 * 1000 + TCK_PS - 1) / TCK_PS;
    localparam int CKEW    = (400 * 1000 + TCK_PS - 1) / TCK_PS;
    localparam int RP      = (15000 + TCK_PS - 1) / TCK_PS;
    localparam int RFC     = (127500 + TCK_PS - 1) / TCK_PS;
    localparam int MRD     = 2;
    localparam int LOCK    = 200;
    localparam int NROWS   = 11;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;

    localparam logic [2:0] K_FIX = 3'd0;
    localparam logic [2:0] K_SRF = 3'd1;
    localparam logic [2:0] K_MR  = 3'd2;
    localparam logic [2:0] K_OIN = 3'd3;
    localparam logic [2:0] K_OUT = 3'd4;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [2:0]  kind;
        logic [13:0] addr;
        logic [15:0] gap;
    } row_t;

    localparam row_t EXP [NROWS] = '{
        '{C_PRE, 2'd0, K_FIX, 14'h0400, 16'(CKEW)},
        '{C_LMR, 2'd2, K_SRF, 14'h0000, 16'(RP)},
        '{C_LMR, 2'd3, K_FIX, 14'h0000, 16'(MRD)},
        '{C_LMR, 2'd1, K_FIX, 14'h0000, 16'(MRD)},
        '{C_LMR, 2'd0, K_FIX, 14'h0100, 16'(MRD)},
        '{C_PRE, 2'd0, K_FIX, 14'h0400, 16'(MRD)},
        '{C_REF, 2'd0, K_FIX, 14'h0000, 16'(RP)},
        '{C_REF, 2'd0, K_FIX, 14'h0000, 16'(RFC)},
        '{C_LMR, 2'd0, K_MR,  14'h0000, 16'(RFC)},
        '{C_LMR, 2'd1, K_OIN, 14'h0000, 16'(MRD)},
        '{C_LMR, 2'd1, K_OUT, 14'h0000, 16'(MRD)}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        pwr_ok;
    logic [13:0] mr_cfg;
    logic [13:0] emr_cfg;
    logic        srf_sel;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [1:0]  ddr_ba;
    logic [13:0] ddr_addr;
    logic        init_done;

    always #10 clk = ~clk;

    ddr2_init_seq #(.T_CK_PS(TCK_PS)) u_ddr2_init_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (pwr_ok),
        .mr_cfg    (mr_cfg),
        .emr_cfg   (emr_cfg),
        .srf_sel   (srf_sel),
        .ddr_cke   (ddr_cke),
        .ddr_cs_n  (ddr_cs_n),
        .ddr_ras_n (ddr_ras_n),
        .ddr_cas_n (ddr_cas_n),
        .ddr_we_n  (ddr_we_n),
        .ddr_ba    (ddr_ba),
        .ddr_addr  (ddr_addr),
        .init_done (init_done)
    );

    int     tests = 0;
    int     fails = 0;
    bit     finished = 0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // trace monitor, samples at the falling edge
    logic        clr = 1'b0;
    int          ev_n;
    longint      ev_cyc [16];
    logic [3:0]  ev_cmd [16];
    logic [1:0]  ev_ba  [16];
    logic [13:0] ev_addr[16];
    longint      cke_rise, done_cyc;
    int          cke_drop, done_drop, post_cmd;
    bit          cke_seen;

    always @(negedge clk) begin
        logic [3:0] c;
        c = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
        if (clr) begin
            ev_n = 0; cke_rise = -1; done_cyc = -1;
            cke_drop = 0; done_drop = 0; post_cmd = 0; cke_seen = 0;
        end else if (!rst) begin
            if (ddr_cke && !cke_seen) begin cke_seen = 1; cke_rise = cyc; end
            if (!ddr_cke && cke_seen) cke_drop++;
            if (init_done && done_cyc < 0) done_cyc = cyc;
            if (done_cyc >= 0 && !init_done) done_drop++;
            if (c != C_NOP) begin
                if (init_done) post_cmd++;
                else begin
                    if (ev_n < 16) begin
                        ev_cyc[ev_n] = cyc; ev_cmd[ev_n] = c;
                        ev_ba[ev_n] = ddr_ba; ev_addr[ev_n] = ddr_addr;
                    end
                    ev_n++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step_n(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [13:0] exp_addr(input logic [2:0] kind, input logic [13:0] fix,
                                             input logic [13:0] mr, input logic [13:0] emr,
                                             input logic srf);
        case (kind)
            K_SRF:   return {6'd0, srf, 7'd0};
            K_MR:    return mr & ~14'h0100;
            K_OIN:   return (emr | 14'h0380) & ~14'h0001;
            K_OUT:   return emr & ~14'h0381;
            default: return fix;
        endcase
    endfunction

    function automatic string row_req(input int i);
        if (i == 0) return "R4";
        if (i <= 4) return "R5";
        if (i <= 7) return "R6";
        if (i == 8) return "R7";
        return "R8";
    endfunction

    task automatic check_reset_state(input string tag);
        check(ddr_cke == 1'b0, "R1", {tag, " cke"}, ddr_cke, 0);
        check({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == C_NOP, "R1", {tag, " cmd"},
              {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, C_NOP);
        check(ddr_ba == 2'd0 && ddr_addr == 14'd0, "R1", {tag, " ba/addr"}, ddr_addr, 0);
        check(init_done == 1'b0, "R1", {tag, " done"}, init_done, 0);
    endtask

    task automatic run_seq(input logic [13:0] mr, input logic [13:0] emr, input logic srf);
        longint raise_cyc;
        int     guard;
        mr_cfg = mr; emr_cfg = emr; srf_sel = srf;
        clr = 1'b1;
        step_n(1);
        clr = 1'b0;
        pwr_ok = 1'b1;
        raise_cyc = cyc;
        guard = 0;
        while (!init_done && guard < PWR + 2000) begin
            step_n(1);
            guard++;
        end
        step_n(300);
        check(cke_rise - raise_cyc == PWR, "R2", "cke rise delay", cke_rise - raise_cyc, PWR);
        check(cke_drop == 0, "R3", "cke low after rise", cke_drop, 0);
        check(ev_n == NROWS, "R6", "command count", ev_n, NROWS);
        for (int i = 0; i < NROWS; i++) begin
            if (i < ev_n) begin
                longint prev;
                logic [13:0] ea;
                prev = (i == 0) ? cke_rise : ev_cyc[i-1];
                ea = exp_addr(EXP[i].kind, EXP[i].addr, mr, emr, srf);
                check(ev_cmd[i] == EXP[i].cmd, row_req(i), $sformatf("row %0d cmd", i),
                      ev_cmd[i], EXP[i].cmd);
                check(ev_ba[i] == EXP[i].ba, row_req(i), $sformatf("row %0d ba", i),
                      ev_ba[i], EXP[i].ba);
                check(ev_addr[i] == ea, row_req(i), $sformatf("row %0d addr", i),
                      ev_addr[i], ea);
                // R9: spacing from previous event
                check(ev_cyc[i] - prev == EXP[i].gap, (i == 0) ? "R4" : "R9",
                      $sformatf("row %0d spacing", i), ev_cyc[i] - prev, EXP[i].gap);
            end
        end
        check(ev_n > 4 && done_cyc - ev_cyc[4] == LOCK, "R10", "done vs DLL reset",
              done_cyc - ev_cyc[4], LOCK);
        check(done_drop == 0 && init_done, "R10", "done sticky", done_drop, 0);
        check(post_cmd == 0, "R10", "commands after done", post_cmd, 0);
        check(ddr_cs_n == 1'b0, "R11", "cs_n after done", ddr_cs_n, 0);
    endtask

    initial begin
        rst = 1'b1; pwr_ok = 1'b0; mr_cfg = '0; emr_cfg = '0; srf_sel = 1'b0;
        clr = 1'b1;
        step_n(3);
        check_reset_state("in reset");
        rst = 1'b0;
        clr = 1'b0;
        step_n(1);
        check_reset_state("after reset");
        step_n(50);
        check(ddr_cke == 1'b0 && ev_n == 0, "R2", "idle without pwr_ok", ev_n, 0);
        pwr_ok = 1'b1;
        step_n(PWR - 10);
        pwr_ok = 1'b0;
        step_n(20);
        check(ddr_cke == 1'b0 && ev_n == 0, "R2", "pwr_ok glitch restarts wait", ddr_cke, 0);

        run_seq(14'h0953, 14'h0245, 1'b1);

        rst = 1'b1; pwr_ok = 1'b0;
        step_n(2);
        check_reset_state("reset after done");
        rst = 1'b0;
        run_seq(14'h0632, 14'h3C7A, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule